// File: doc/BRIEF.md
# Debug-Port Flash Access Sequencer

This block sits behind the register file of a debug port. It holds a control register, a 17-bit address register and an 8-bit data register. An access to the data register becomes a flash operation, and the mode fields of the control register choose which one. A write to the data register can store the byte, program it into flash, or erase a page, the whole user area or the scratchpad sectors. A read of the data register can return the held byte or start a flash byte read.

The flash array sits behind a request/acknowledge port. The port carries a command code, a 17-bit address, a write byte and a flag that selects the scratchpad space. The request is held until the array acknowledges it. A busy output covers that same window. While busy, the block ignores every register access, so a debugger can poll busy before each access.

Top module: `dbg_flash_seq`

## Requirements
- R1: After reset, ctrl_q, addr_q and data_q are 0, and busy and fl_req are 0.
- R2: While idle, ctrl_we, addr_we and data_we load ctrl_q, addr_q and data_q from wdata. While busy, all register writes and data reads are ignored.
- R3: The control register fields are bit 7 scratchpad select, bits 6:4 write mode and bits 3:0 read mode. With write mode 000, or any reserved code 011 to 111, a data write only stores the byte and raises no request.
- R4: With write mode 001, a data write requests fl_cmd 1 (program) at addr_q with fl_wdata equal to the byte. On acknowledge, addr_q increases by one and wraps at 17 bits.
- R5: With write mode 010 and byte 0xA5, a data write requests fl_cmd 2 (page erase) at addr_q with its low log2(PAGE_BYTES) bits cleared (10 bits by default). addr_q does not change. Any other byte is stored and raises no request.
- R6: In keyed erase with scratchpad select 0, an address of 0x1FBFE or 0x1FBFF requests fl_cmd 3 (erase all user space) with fl_addr 0.
- R7: With scratchpad select 1, requests carry fl_scr 1 and are allowed only at addresses 0x000 to 0x0FF. A page erase there uses a 128-byte sector base (low 7 bits cleared). A keyed erase at 0x400 requests fl_cmd 4 (erase both sectors) at 0x400. Any other address raises no request.
- R8: With read mode 0001, a data read requests fl_cmd 0 (read) at addr_q. On acknowledge, fl_rdata is loaded into data_q and addr_q does not change. Read mode 0000, or any reserved read code, raises no request and leaves data_q unchanged.
- R9: busy and fl_req rise on the clock edge that accepts the access and fall on the edge where fl_ack is sampled. fl_cmd, fl_addr, fl_wdata and fl_scr stay stable while the request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| addr_we | input | 1 | Address register write strobe |
| data_we | input | 1 | Data register write strobe |
| data_re | input | 1 | Data register read strobe |
| wdata | input | 17 | Register write value |
| ctrl_q | output | 8 | Control register |
| addr_q | output | 17 | Address register |
| data_q | output | 8 | Data register |
| busy | output | 1 | Flash operation outstanding |
| fl_req | output | 1 | Flash request |
| fl_cmd | output | 3 | Flash command code |
| fl_addr | output | 17 | Flash address |
| fl_wdata | output | 8 | Flash program byte |
| fl_scr | output | 1 | Scratchpad space select |
| fl_ack | input | 1 | Flash acknowledge |
| fl_rdata | input | 8 | Flash read byte |

## Verification
The checker tests these rules on every cycle:
- the request stays stable until it is acknowledged;
- the address increments after a program and stays put after a read;
- an erase never starts unless the key byte is held;
- erase addresses are aligned to the page or sector base;
- scratchpad requests never leave the 0x000 to 0x0FF window;
- mode 000 never raises a request;
- the control register stays frozen while busy.

The bench scenarios cover the rest:
- which command each mode, key and address combination should produce, including the 0x1FBFE/0x1FBFF and 0x400 special addresses;
- address wrap at 0x1FFFF;
- the capture of read data;
- rejection of accesses made while busy.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    localparam int FSEQ_AW = 17;
    localparam int FSEQ_DW = 8;

    typedef enum logic [2:0] {
        FCMD_READ      = 3'd0,
        FCMD_PROG      = 3'd1,
        FCMD_ERASE_PG  = 3'd2,
        FCMD_ERASE_ALL = 3'd3,
        FCMD_ERASE_SCR = 3'd4
    } fl_cmd_e;

    // control register field positions
    localparam int CTL_SCR_BIT = 7;
    localparam int CTL_WM_HI   = 6;
    localparam int CTL_WM_LO   = 4;
    localparam int CTL_RM_HI   = 3;
    localparam int CTL_RM_LO   = 0;

    localparam logic [2:0] WMODE_PROG  = 3'b001;
    localparam logic [2:0] WMODE_ERASE = 3'b010;
    localparam logic [3:0] RMODE_FETCH = 4'b0001;
endpackage

// File: rtl/fseq_wr_decode.sv
module fseq_wr_decode
    import fseq_pkg::*;
#(
    parameter int          AW           = FSEQ_AW,
    parameter int          DW           = FSEQ_DW,
    parameter int          PAGE_BYTES   = 1024,
    parameter int          SCR_BYTES    = 128,
    parameter logic [DW-1:0] ERASE_KEY  = 8'hA5,
    parameter logic [AW-1:0] ALL_ADDR   = 17'h1FBFE,
    parameter logic [AW-1:0] SCR_ALL    = 17'h400
) (
    input  logic          scr,
    input  logic [2:0]    wmode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] byte_in,
    output logic          go,
    output fl_cmd_e       cmd,
    output logic [AW-1:0] faddr
);
    localparam int          SCR_SPAN = 2 * SCR_BYTES;
    localparam logic [AW-1:0] PG_MASK  = ~AW'(PAGE_BYTES - 1);
    localparam logic [AW-1:0] SEC_MASK = ~AW'(SCR_BYTES - 1);

    logic scr_in_range;
    logic all_hit;

    assign scr_in_range = addr < AW'(SCR_SPAN);
    assign all_hit      = (addr[AW-1:1] == ALL_ADDR[AW-1:1]);

    always_comb begin
        go    = 1'b0;
        cmd   = FCMD_PROG;
        faddr = addr;
        if (wmode == WMODE_PROG) begin
            go = !scr || scr_in_range;
        end else if (wmode == WMODE_ERASE && byte_in == ERASE_KEY) begin
            if (scr) begin
                if (addr == SCR_ALL) begin
                    go  = 1'b1;
                    cmd = FCMD_ERASE_SCR;
                end else if (scr_in_range) begin
                    go    = 1'b1;
                    cmd   = FCMD_ERASE_PG;
                    faddr = addr & SEC_MASK;
                end
            end else if (all_hit) begin
                go    = 1'b1;
                cmd   = FCMD_ERASE_ALL;
                faddr = '0;
            end else begin
                go    = 1'b1;
                cmd   = FCMD_ERASE_PG;
                faddr = addr & PG_MASK;
            end
        end
    end
endmodule

// File: rtl/fseq_rd_decode.sv
module fseq_rd_decode
    import fseq_pkg::*;
#(
    parameter int AW        = FSEQ_AW,
    parameter int SCR_BYTES = 128
) (
    input  logic          scr,
    input  logic [3:0]    rmode,
    input  logic [AW-1:0] addr,
    output logic          go
);
    localparam int SCR_SPAN = 2 * SCR_BYTES;

    assign go = (rmode == RMODE_FETCH) && (!scr || (addr < AW'(SCR_SPAN)));
endmodule

// File: rtl/dbg_flash_seq.sv
module dbg_flash_seq
    import fseq_pkg::*;
#(
    parameter int AW         = FSEQ_AW,
    parameter int DW         = FSEQ_DW,
    parameter int PAGE_BYTES = 1024,
    parameter int SCR_BYTES  = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          addr_we,
    input  logic          data_we,
    input  logic          data_re,
    input  logic [AW-1:0] wdata,
    output logic [7:0]    ctrl_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          busy,
    output logic          fl_req,
    output logic [2:0]    fl_cmd,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic          fl_scr,
    input  logic          fl_ack,
    input  logic [DW-1:0] fl_rdata
);
    localparam int PG_LSB = $clog2(PAGE_BYTES);

    typedef struct packed {
        logic [7:0]    ctrl;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          req;
        fl_cmd_e       cmd;
        logic [AW-1:0] fa;
        logic [DW-1:0] fw;
        logic          scr;
    } seq_state_t;

    seq_state_t s_q, s_d;

    logic          wr_go, rd_go;
    fl_cmd_e       wr_cmd;
    logic [AW-1:0] wr_addr;

    fseq_wr_decode #(
        .AW(AW), .DW(DW), .PAGE_BYTES(PAGE_BYTES), .SCR_BYTES(SCR_BYTES)
    ) u_wdec (
        .scr     (s_q.ctrl[CTL_SCR_BIT]),
        .wmode   (s_q.ctrl[CTL_WM_HI:CTL_WM_LO]),
        .addr    (s_q.addr),
        .byte_in (wdata[DW-1:0]),
        .go      (wr_go),
        .cmd     (wr_cmd),
        .faddr   (wr_addr)
    );

    fseq_rd_decode #(
        .AW(AW), .SCR_BYTES(SCR_BYTES)
    ) u_rdec (
        .scr   (s_q.ctrl[CTL_SCR_BIT]),
        .rmode (s_q.ctrl[CTL_RM_HI:CTL_RM_LO]),
        .addr  (s_q.addr),
        .go    (rd_go)
    );

    always_comb begin
        s_d = s_q;
        if (!s_q.req) begin
            if (ctrl_we) s_d.ctrl = wdata[7:0];
            if (addr_we) s_d.addr = wdata;
            if (data_we) begin
                s_d.data = wdata[DW-1:0];
                if (wr_go) begin
                    s_d.req = 1'b1;
                    s_d.cmd = wr_cmd;
                    s_d.fa  = wr_addr;
                    s_d.fw  = wdata[DW-1:0];
                    s_d.scr = s_q.ctrl[CTL_SCR_BIT];
                end
            end else if (data_re && rd_go) begin
                s_d.req = 1'b1;
                s_d.cmd = FCMD_READ;
                s_d.fa  = s_q.addr;
                s_d.scr = s_q.ctrl[CTL_SCR_BIT];
            end
        end else if (fl_ack) begin
            s_d.req = 1'b0;
            if (s_q.cmd == FCMD_PROG) s_d.addr = s_q.addr + AW'(1);
            if (s_q.cmd == FCMD_READ) s_d.data = fl_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ctrl: '0, addr: '0, data: '0, req: 1'b0, cmd: FCMD_READ,
                     fa: '0, fw: '0, scr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_q   = s_q.ctrl;
    assign addr_q   = s_q.addr;
    assign data_q   = s_q.data;
    assign busy     = s_q.req;
    assign fl_req   = s_q.req;
    assign fl_cmd   = s_q.cmd;
    assign fl_addr  = s_q.fa;
    assign fl_wdata = s_q.fw;
    assign fl_scr   = s_q.scr;
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int AW     = 17,
    parameter int PG_LSB = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          data_we,
    input logic          busy,
    input logic          fl_req,
    input logic          fl_ack,
    input logic [2:0]    fl_cmd,
    input logic [AW-1:0] fl_addr,
    input logic          fl_scr,
    input logic [7:0]    ctrl_q,
    input logic [AW-1:0] addr_q,
    input logic [7:0]    data_q
);
    p_busy_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fl_ack) |=> $stable(ctrl_q));

    p_mode0_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !busy && ctrl_q[6:4] == 3'b000) |=> !fl_req);

    p_prog_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_ack && fl_cmd == 3'd1) |=> addr_q == AW'($past(addr_q) + 1'b1));

    p_erase_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fl_req) && (fl_cmd inside {3'd2, 3'd3, 3'd4})) |-> data_q == 8'hA5);

    p_page_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_cmd == 3'd2 && !fl_scr) |-> fl_addr[PG_LSB-1:0] == '0);

    p_erase_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_cmd == 3'd3) |-> (fl_addr == '0 && !fl_scr));

    p_scr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_scr && fl_cmd != 3'd4) |-> fl_addr < AW'(256));

    p_read_noinc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_ack && fl_cmd == 3'd0) |=> $stable(addr_q));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_cmd) && $stable(fl_addr) && $stable(fl_scr)));
endmodule

bind dbg_flash_seq fseq_chk #(.AW(AW), .PG_LSB(PG_LSB)) u_chk (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .busy(busy), .fl_req(fl_req),
    .fl_ack(fl_ack), .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_scr(fl_scr),
    .ctrl_q(ctrl_q), .addr_q(addr_q), .data_q(data_q)
);

// File: tb/sim_dbg_flash_seq.sv
module sim_dbg_flash_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 0, addr_we = 0, data_we = 0, data_re = 0;
    logic [16:0] wdata = '0;
    logic [7:0]  ctrl_q, data_q, fl_wdata;
    logic [16:0] addr_q, fl_addr;
    logic        busy, fl_req, fl_scr;
    logic [2:0]  fl_cmd;
    logic        fl_ack = 1'b0;
    logic [7:0]  fl_rdata = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic [7:0]  m_ctrl = '0;
    logic [16:0] m_addr = '0;
    logic [7:0]  m_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_flash_seq u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .addr_we(addr_we),
        .data_we(data_we), .data_re(data_re), .wdata(wdata),
        .ctrl_q(ctrl_q), .addr_q(addr_q), .data_q(data_q), .busy(busy),
        .fl_req(fl_req), .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_scr(fl_scr), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Expected outcome of a data access, from the requirements.
    function automatic void exp_op(input logic wr, input logic [7:0] c, input logic [16:0] a,
                                   input logic [7:0] b, output logic go,
                                   output logic [2:0] cmd, output logic [16:0] fa);
        logic scr, inr;
        scr = c[7];
        inr = (a <= 17'h0FF);
        go  = 1'b0;
        cmd = 3'd0;
        fa  = a;
        if (wr) begin
            if (c[6:4] == 3'b001) begin
                go  = !scr || inr;
                cmd = 3'd1;
            end else if (c[6:4] == 3'b010 && b == 8'hA5) begin
                if (scr) begin
                    if (a == 17'h400) begin go = 1; cmd = 3'd4; end
                    else if (inr) begin go = 1; cmd = 3'd2; fa = {a[16:7], 7'b0}; end
                end else if (a == 17'h1FBFE || a == 17'h1FBFF) begin
                    go = 1; cmd = 3'd3; fa = '0;
                end else begin
                    go = 1; cmd = 3'd2; fa = {a[16:10], 10'b0};
                end
            end
        end else begin
            go = (c[3:0] == 4'b0001) && (!scr || inr);
        end
    endfunction

    task automatic check_regs(input string tag);
        chk({tag, " ctrl R2"}, ctrl_q, m_ctrl);
        chk({tag, " addr R2"}, addr_q, m_addr);
        chk({tag, " data R2"}, data_q, m_data);
    endtask

    // Serve an outstanding request; optionally poke registers while busy (R2).
    task automatic serve(input logic [2:0] cmd, input bit poke);
        int d;
        logic [7:0] rb;
        d = poke ? 1 + int'($urandom % 3) : int'($urandom % 4);
        for (int i = 0; i < d; i++) begin
            if (poke && i == 0) begin
                ctrl_we = 1; addr_we = 1; data_we = 1;
                wdata = {$urandom} [16:0];
            end
            @(negedge clk);
            ctrl_we = 0; addr_we = 0; data_we = 0;
            chk("busy hold R9", {31'b0, busy}, 32'd1);
        end
        rb = mem_byte(fl_addr);
        fl_ack = 1; fl_rdata = rb;
        @(negedge clk);
        fl_ack = 0;
        if (cmd == 3'd1) m_addr = m_addr + 17'd1;
        if (cmd == 3'd0) m_data = rb;
        chk("busy drop R9", {31'b0, busy}, 32'd0);
        check_regs(poke ? "after busy poke R2" : "after ack");
    endtask

    // kind: 0 ctrl write, 1 addr write, 2 data write, 3 data read
    task automatic access(input int kind, input logic [16:0] val, input bit poke);
        logic go; logic [2:0] cmd; logic [16:0] fa;
        exp_op(kind == 2, m_ctrl, m_addr, val[7:0], go, cmd, fa);
        if (kind < 2) go = 0;
        @(negedge clk);
        wdata = val;
        ctrl_we = (kind == 0); addr_we = (kind == 1);
        data_we = (kind == 2); data_re = (kind == 3);
        @(negedge clk);
        ctrl_we = 0; addr_we = 0; data_we = 0; data_re = 0;
        if (kind == 0) m_ctrl = val[7:0];
        if (kind == 1) m_addr = val;
        if (kind == 2) m_data = val[7:0];
        check_regs("access");
        chk("req R3 R4 R5 R6 R7 R8", {31'b0, fl_req}, {31'b0, go});
        if (go) begin
            chk("cmd R4 R5 R6 R7 R8", {29'b0, fl_cmd}, {29'b0, cmd});
            chk("addr R5 R6 R7", {15'b0, fl_addr}, {15'b0, fa});
            chk("scr R7", {31'b0, fl_scr}, {31'b0, m_ctrl[7]});
            if (cmd == 3'd1) chk("wdata R4", {24'b0, fl_wdata}, {24'b0, val[7:0]});
            serve(cmd, poke);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("reset ctrl R1", ctrl_q, 0);
        chk("reset addr R1", addr_q, 0);
        chk("reset data R1", data_q, 0);
        chk("reset busy R1", {31'b0, busy}, 0);
        chk("reset req R1", {31'b0, fl_req}, 0);
        rst_n = 1;
        @(negedge clk);

        // R3 mode 000 and reserved write modes only store
        access(1, 17'h00123, 0);
        access(2, 17'h000A5, 0);
        access(0, 17'h00030, 0);
        access(2, 17'h000A5, 0);
        access(0, 17'h00070, 0);
        access(2, 17'h00011, 0);
        // R4 program with wrap at top of address space
        access(0, 17'h00010, 0);
        access(1, 17'h1FFFF, 0);
        access(2, 17'h0003C, 0);
        chk("wrap R4", addr_q, 0);
        access(2, 17'h000C3, 1);
        // R5 keyed page erase and wrong key
        access(0, 17'h00020, 0);
        access(1, 17'h12345, 0);
        access(2, 17'h000A5, 0);
        chk("erase noinc R5", addr_q, 17'h12345);
        access(2, 17'h000A4, 0);
        // R6 whole user area erase at both magic addresses
        access(1, 17'h1FBFE, 0);
        access(2, 17'h000A5, 0);
        access(1, 17'h1FBFF, 0);
        access(2, 17'h000A5, 0);
        // R7 scratchpad
        access(0, 17'h000A0, 0);
        access(1, 17'h000C5, 0);
        access(2, 17'h000A5, 0);
        access(1, 17'h00400, 0);
        access(2, 17'h000A5, 0);
        access(1, 17'h00100, 0);
        access(2, 17'h000A5, 0);
        access(0, 17'h00090, 0);
        access(2, 17'h00077, 0);
        access(1, 17'h000FF, 0);
        access(2, 17'h00077, 0);
        // R8 read modes
        access(0, 17'h00001, 0);
        access(1, 17'h0ABCD, 0);
        access(3, 17'h0, 0);
        access(0, 17'h00000, 0);
        access(3, 17'h0, 0);
        access(0, 17'h00002, 0);
        access(3, 17'h0, 0);
        access(0, 17'h00081, 0);
        access(1, 17'h00200, 0);
        access(3, 17'h0, 0);
        access(1, 17'h00042, 0);
        access(3, 17'h0, 1);

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int kind;
            logic [16:0] v;
            kind = int'($urandom % 4);
            v = {$urandom} [16:0];
            case (kind)
                0: begin
                    v[16:8] = '0;
                    case ($urandom % 4)
                        0: v[6:4] = 3'b000;
                        1: v[6:4] = 3'b001;
                        2: v[6:4] = 3'b010;
                        default: ;
                    endcase
                    if ($urandom % 3 != 0) v[3:0] = {3'b0, v[3]};
                end
                1: case ($urandom % 6)
                        0: v = 17'h1FBFE | {16'b0, v[0]};
                        1: v = 17'h00400;
                        2: v = {9'b0, v[7:0]};
                        3: v = 17'h1FFFF;
                        default: ;
                   endcase
                2: if ($urandom % 2 == 0) v = 17'h000A5;
                default: ;
            endcase
            access(kind, v, ($urandom % 5) == 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog R9 act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule